// File: doc/BRIEF.md
# Macroblock Header Differential Encoder

This block turns the per-macroblock side information of one group of blocks into the numeric header fields that a later variable-length coder packs into the stream. Each input beat describes one macroblock position: its absolute address (1 to 33, three rows of eleven), whether it is transmitted or skipped, its motion vector, whether it is motion compensated, whether it is intra coded, and six flags that say which of its blocks carry coefficients. A separate flag marks the first beat of a new group.

For every transmitted macroblock the block returns an address increment, a horizontal and a vertical vector difference, and the coded block pattern number. It keeps the address and vector of the last transmitted macroblock between beats. The vector predictor is reset to zero at each row start, after a gap in transmitted addresses, and after a macroblock without motion compensation. Skipped macroblocks are accepted but produce nothing. Input and output use a valid/ready handshake with registered outputs one cycle behind acceptance.

Top module: `mbHeaderEnc`

## Requirements
- R1: The first transmitted macroblock after a beat with inFirst high reports its absolute address as outAddrInc; inFirst may arrive on a skipped beat.
- R2: Every later transmitted macroblock in the group reports its address minus the address of the last transmitted macroblock, i.e. one plus the count of skipped macroblocks in between.
- R3: A beat with inCoded low is accepted and produces no output beat.
- R4: For a motion-compensated macroblock, outMvdX and outMvdY equal the current vector component minus the predictor component, each as a signed 6-bit value.
- R5: The predictor is zero for macroblocks at addresses 1, 12 and 23 (row starts).
- R6: The predictor is zero when the address increment is not 1 or when the last transmitted macroblock was not motion compensated; otherwise it is that macroblock's vector.
- R7: A macroblock with inMc low reports zero vector differences and counts as not motion compensated for the next one.
- R8: A vector component input of -16 (5-bit pattern 10000) is treated as -15; components stay in -15..+15 and differences in -30..+30.
- R9: outCbp = 32*inBlkHas[0] + 16*inBlkHas[1] + 8*inBlkHas[2] + 4*inBlkHas[3] + 2*inBlkHas[4] + inBlkHas[5]; bits 0..3 are the luminance blocks, bit 4 the Cb block, bit 5 the Cr block.
- R10: An intra macroblock reports outCbp = 63 and zero vector differences, and counts as not motion compensated, whatever inMc and inBlkHas say.
- R11: A transmitted beat accepted on a clock edge shows outValid high after that edge; an output beat stays unchanged while outReady is low; inReady is high whenever no output beat is pending.
- R12: During and right after reset outValid is low and inReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Input beat accepted when high with inValid |
| inFirst | input | 1 | Beat is the first of a new group |
| inAddr | input | 6 | Absolute macroblock address, 1..33 |
| inCoded | input | 1 | Macroblock is transmitted |
| inMc | input | 1 | Macroblock is motion compensated |
| inIntra | input | 1 | Macroblock is intra coded |
| inMvX | input | 5 | Horizontal vector, signed |
| inMvY | input | 5 | Vertical vector, signed |
| inBlkHas | input | 6 | Per-block coefficient-present flags, bit 0 = block 1 |
| outValid | output | 1 | Output beat valid |
| outReady | input | 1 | Downstream takes the output beat |
| outAddrInc | output | 6 | Address increment |
| outMvdX | output | 6 | Horizontal vector difference, signed |
| outMvdY | output | 6 | Vertical vector difference, signed |
| outCbp | output | 6 | Coded block pattern number |

## Verification
Every result of this block is due exactly one clock edge after the transmitted beat is accepted, and a skipped beat must leave outValid low after that same edge unless an earlier beat is still held. The bench drives inputs and takes the acceptance decision at the falling edge, advances its reference model across one rising edge, and compares outValid and all four fields at the next falling edge, every cycle. Random downstream stalls exercise the hold case, where the expected beat stays unchanged until outReady is seen high.

// File: rtl/mbhdr_pkg.sv
package mbhdr_pkg;
  localparam int ROW_LEN  = 11;
  localparam int ROW_CNT  = 3;
  localparam int MB_TOTAL = ROW_LEN * ROW_CNT;
  localparam int ADDR_W   = $clog2(MB_TOTAL + 1);
  localparam int MV_W     = 5;
  localparam int NBLK     = 6;

  // strobes from control to datapath for one accepted beat
  typedef struct packed {
    logic              emit;      // transmitted beat accepted this cycle
    logic              predZero;  // vector predictor forced to zero
    logic              mcNow;     // current macroblock counts as motion compensated
    logic [ADDR_W-1:0] addrInc;   // address increment for this beat
  } strobe_t;
endpackage

// File: rtl/mbhdr_ctrl.sv
module mbhdr_ctrl
  import mbhdr_pkg::*;
#(
  parameter int ROWLEN = ROW_LEN,
  parameter int ROWCNT = ROW_CNT,
  parameter int AW     = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          inFirst,
  input  logic [AW-1:0] inAddr,
  input  logic          inCoded,
  input  logic          inMc,
  input  logic          inIntra,
  input  logic          outReady,
  output logic          inReady,
  output logic          outValid,
  output strobe_t       stb
);
  logic [AW-1:0]     lastAddr;
  logic              lastMc;
  logic [AW-1:0]     effLast;
  logic              effMc;
  logic              take;
  logic [ROWCNT-1:0] rowHit;
  logic              rowStart;

  // one comparator per row start address
  for (genvar r = 0; r < ROWCNT; r++) begin : gRowStart
    assign rowHit[r] = (inAddr == AW'(r * ROWLEN + 1));
  end
  assign rowStart = |rowHit;

  assign inReady = !outValid || outReady;
  assign take    = inValid && inReady;

  always_comb begin
    effLast      = inFirst ? '0 : lastAddr;
    effMc        = inFirst ? 1'b0 : lastMc;
    stb.emit     = take && inCoded;
    stb.mcNow    = inMc && !inIntra;
    stb.addrInc  = inAddr - effLast;
    stb.predZero = rowStart || (stb.addrInc != AW'(1)) || !effMc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastAddr <= '0;
      lastMc   <= 1'b0;
      outValid <= 1'b0;
    end else begin
      if (stb.emit) begin
        lastAddr <= inAddr;
        lastMc   <= stb.mcNow;
      end else if (take && inFirst) begin
        lastAddr <= '0;
        lastMc   <= 1'b0;
      end
      if (stb.emit)      outValid <= 1'b1;
      else if (outReady) outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/mbhdr_dp.sv
module mbhdr_dp
  import mbhdr_pkg::*;
#(
  parameter int MVW = MV_W,
  parameter int AW  = ADDR_W,
  parameter int NB  = NBLK
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic                  inIntra,
  input  logic signed [MVW-1:0] inMvX,
  input  logic signed [MVW-1:0] inMvY,
  input  logic [NB-1:0]         inBlkHas,
  output logic [AW-1:0]         outAddrInc,
  output logic signed [MVW:0]   outMvdX,
  output logic signed [MVW:0]   outMvdY,
  output logic [NB-1:0]         outCbp
);
  localparam logic signed [MVW-1:0] MV_MIN = {1'b1, {(MVW-1){1'b0}}};
  localparam logic signed [MVW-1:0] MV_LOW = {1'b1, {(MVW-2){1'b0}}, 1'b1};

  logic signed [MVW-1:0] prevX, prevY, curX, curY, predX, predY;
  logic signed [MVW:0]   dX, dY;
  logic [NB-1:0]         cbpRaw, cbpNext;

  function automatic logic signed [MVW-1:0] clampMv(input logic signed [MVW-1:0] v);
    return (v == MV_MIN) ? MV_LOW : v;
  endfunction

  // block 1 carries the highest weight
  for (genvar b = 0; b < NB; b++) begin : gCbp
    assign cbpRaw[NB-1-b] = inBlkHas[b];
  end

  always_comb begin
    curX    = clampMv(inMvX);
    curY    = clampMv(inMvY);
    predX   = stb.predZero ? '0 : prevX;
    predY   = stb.predZero ? '0 : prevY;
    dX      = stb.mcNow ? ($signed({curX[MVW-1], curX}) - $signed({predX[MVW-1], predX})) : '0;
    dY      = stb.mcNow ? ($signed({curY[MVW-1], curY}) - $signed({predY[MVW-1], predY})) : '0;
    cbpNext = inIntra ? '1 : cbpRaw;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevX      <= '0;
      prevY      <= '0;
      outAddrInc <= '0;
      outMvdX    <= '0;
      outMvdY    <= '0;
      outCbp     <= '0;
    end else if (stb.emit) begin
      prevX      <= stb.mcNow ? curX : '0;
      prevY      <= stb.mcNow ? curY : '0;
      outAddrInc <= stb.addrInc;
      outMvdX    <= dX;
      outMvdY    <= dY;
      outCbp     <= cbpNext;
    end
  end
endmodule

// File: rtl/mbHeaderEnc.sv
module mbHeaderEnc
  import mbhdr_pkg::*;
#(
  parameter int ROWLEN = ROW_LEN,
  parameter int ROWCNT = ROW_CNT,
  parameter int MVW    = MV_W,
  parameter int NB     = NBLK
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  output logic                 inReady,
  input  logic                 inFirst,
  input  logic [ADDR_W-1:0]    inAddr,
  input  logic                 inCoded,
  input  logic                 inMc,
  input  logic                 inIntra,
  input  logic signed [MVW-1:0] inMvX,
  input  logic signed [MVW-1:0] inMvY,
  input  logic [NB-1:0]        inBlkHas,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [ADDR_W-1:0]    outAddrInc,
  output logic signed [MVW:0]  outMvdX,
  output logic signed [MVW:0]  outMvdY,
  output logic [NB-1:0]        outCbp
);
  strobe_t stb;

  mbhdr_ctrl #(.ROWLEN(ROWLEN), .ROWCNT(ROWCNT), .AW(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFirst(inFirst),
    .inAddr(inAddr), .inCoded(inCoded), .inMc(inMc), .inIntra(inIntra),
    .outReady(outReady), .inReady(inReady), .outValid(outValid), .stb(stb)
  );

  mbhdr_dp #(.MVW(MVW), .AW(ADDR_W), .NB(NB)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .inIntra(inIntra),
    .inMvX(inMvX), .inMvY(inMvY), .inBlkHas(inBlkHas),
    .outAddrInc(outAddrInc), .outMvdX(outMvdX), .outMvdY(outMvdY), .outCbp(outCbp)
  );
endmodule

// File: rtl/mbhdr_chk.sv
module mbhdr_chk #(
  parameter int MVW = 5,
  parameter int AW  = 6,
  parameter int NB  = 6
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic                 inReady,
  input logic                 inCoded,
  input logic                 inIntra,
  input logic                 outValid,
  input logic                 outReady,
  input logic [AW-1:0]        outAddrInc,
  input logic signed [MVW:0]  outMvdX,
  input logic signed [MVW:0]  outMvdY,
  input logic [NB-1:0]        outCbp
);
  localparam int LIM = 2 * ((1 << (MVW - 1)) - 1);

  assert_emit_next_R11: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inCoded) |=> outValid);

  assert_skip_silent_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !inCoded) |=> !outValid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outAddrInc) && $stable(outMvdX)
                                 && $stable(outMvdY) && $stable(outCbp)));

  assert_ready_R11: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady);

  assert_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (int'(outMvdX) >= -LIM && int'(outMvdX) <= LIM
                  && int'(outMvdY) >= -LIM && int'(outMvdY) <= LIM));

  assert_intra_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inCoded && inIntra) |=> (outCbp == '1 && outMvdX == 0 && outMvdY == 0));
endmodule

bind mbHeaderEnc mbhdr_chk #(.MVW(MVW), .AW(mbhdr_pkg::ADDR_W), .NB(NB)) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inCoded(inCoded),
  .inIntra(inIntra), .outValid(outValid), .outReady(outReady), .outAddrInc(outAddrInc),
  .outMvdX(outMvdX), .outMvdY(outMvdY), .outCbp(outCbp)
);

// File: tb/mbHeaderEnc_test.sv
`timescale 1ns/1ps
module mbHeaderEnc_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inFirst = 1'b0, inCoded = 1'b0, inMc = 1'b0, inIntra = 1'b0;
  logic [5:0] inAddr = '0;
  logic signed [4:0] inMvX = '0, inMvY = '0;
  logic [5:0] inBlkHas = '0;
  logic outReady = 1'b1;
  logic inReady, outValid;
  logic [5:0] outAddrInc, outCbp;
  logic signed [5:0] outMvdX, outMvdY;

  int total = 0, bad = 0;
  bit finished = 0;
  bit bp = 0;

  // reference model state
  int pa = 0, pm = 0, px = 0, py = 0;
  bit expValid = 0;
  int expInc, expX, expY, expCbp;
  string incTag, mvTag;

  always #2.5 clk = ~clk;

  mbHeaderEnc uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inFirst(inFirst),
    .inAddr(inAddr), .inCoded(inCoded), .inMc(inMc), .inIntra(inIntra),
    .inMvX(inMvX), .inMvY(inMvY), .inBlkHas(inBlkHas), .outValid(outValid),
    .outReady(outReady), .outAddrInc(outAddrInc), .outMvdX(outMvdX),
    .outMvdY(outMvdY), .outCbp(outCbp)
  );

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int clampV(int v);
    return (v < -15) ? -15 : v;
  endfunction

  // one clock: decide at falling edge, advance model over the rising edge, compare at next falling edge
  task automatic tick(output bit acc);
    outReady = bp ? ($urandom % 4 != 0) : 1'b1;
    #0.1;
    if (!expValid) check(inReady === 1'b1, "R11 inReady", int'(inReady), 1);
    acc = inValid && inReady;
    if (acc && inFirst) begin pa = 0; pm = 0; px = 0; py = 0; end
    if (acc && inCoded) begin
      int addr = int'(inAddr);
      int inc = addr - pa;
      int mc = (inMc && !inIntra) ? 1 : 0;
      int cx = clampV(int'(inMvX));
      int cy = clampV(int'(inMvY));
      int rowSt = ((addr - 1) % 11 == 0) ? 1 : 0;
      int pz = (rowSt || inc != 1 || !pm) ? 1 : 0;
      int prx = pz ? 0 : px;
      int pry = pz ? 0 : py;
      incTag = (pa == 0) ? "R1" : "R2";
      expInc = inc;
      expX = mc ? cx - prx : 0;
      expY = mc ? cy - pry : 0;
      expCbp = 0;
      for (int k = 0; k < 6; k++) if (inBlkHas[k]) expCbp += (32 >> k);
      if (inIntra) expCbp = 63;
      if (inIntra) mvTag = "R10";
      else if (!mc) mvTag = "R7";
      else if (cx != int'(inMvX) || cy != int'(inMvY)) mvTag = "R8";
      else if (rowSt) mvTag = "R5";
      else if (pz) mvTag = "R6";
      else mvTag = "R4";
      pa = addr; pm = mc;
      px = mc ? cx : 0; py = mc ? cy : 0;
      expValid = 1;
    end else if (!(expValid && !outReady)) begin
      expValid = 0;
    end
    @(posedge clk);
    @(negedge clk);
    check(outValid === expValid, acc && !inCoded ? "R3 outValid" : "R11 outValid",
          int'(outValid), int'(expValid));
    if (expValid) begin
      check(int'(outAddrInc) == expInc, incTag, int'(outAddrInc), expInc);
      check(int'(outMvdX) == expX, mvTag, int'(outMvdX), expX);
      check(int'(outMvdY) == expY, mvTag, int'(outMvdY), expY);
      check(int'(outCbp) == expCbp, inIntra ? "R10 cbp" : "R9 cbp", int'(outCbp), expCbp);
    end
  endtask

  task automatic send(bit f, int a, bit c, bit m, bit i, int x, int y, bit [5:0] b);
    bit acc;
    inValid = 1; inFirst = f; inAddr = 6'(a); inCoded = c; inMc = m; inIntra = i;
    inMvX = 5'(x); inMvY = 5'(y); inBlkHas = b;
    do tick(acc); while (!acc);
    inValid = 0;
  endtask

  task automatic idle(int n);
    bit acc;
    for (int k = 0; k < n; k++) tick(acc);
  endtask

  initial begin
    @(negedge clk);
    check(outValid === 1'b0, "R12 outValid in reset", int'(outValid), 0);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(outValid === 1'b0, "R12 outValid after reset", int'(outValid), 0);
    check(inReady === 1'b1, "R12 inReady after reset", int'(inReady), 1);

    // directed group: chains, gaps, non-compensated, row starts, clamp, intra
    send(1, 1, 1, 1, 0, 3, -2, 6'b000001);
    send(0, 2, 1, 1, 0, 5, 1, 6'b100000);
    send(0, 3, 1, 1, 0, -4, 7, 6'b010110);
    send(0, 4, 1, 0, 0, 6, 6, 6'b001000);
    send(0, 5, 1, 1, 0, 2, 2, 6'b111111);
    send(0, 6, 0, 1, 0, 9, 9, 6'b000000);
    send(0, 7, 1, 1, 0, 1, 1, 6'b000011);
    send(0, 11, 1, 1, 0, 4, -3, 6'b000100);
    send(0, 12, 1, 1, 0, -6, 2, 6'b000000);
    send(0, 13, 1, 1, 0, -5, 5, 6'b010000);
    send(0, 22, 1, 1, 0, 7, 7, 6'b000001);
    send(0, 23, 1, 1, 0, -16, 15, 6'b000001);
    send(0, 24, 1, 1, 0, -16, -16, 6'b000010);
    send(0, 25, 1, 1, 1, 3, 3, 6'b000000);
    send(0, 26, 1, 1, 0, 2, 2, 6'b000000);
    idle(2);
    // group starting past address 1
    send(1, 5, 1, 1, 0, 1, 2, 6'b100001);
    send(0, 6, 1, 1, 0, 15, -15, 6'b000000);
    // group start flagged on a skipped beat
    send(1, 1, 0, 0, 0, 0, 0, 6'b000000);
    send(0, 3, 1, 1, 0, 4, 4, 6'b001100);

    // random groups with downstream stalls
    bp = 1;
    for (int g = 0; g < 8; g++) begin
      bit first = 1;
      for (int a = 1; a <= 33; a++) begin
        bit c = ($urandom % 10) < 6;
        int x = int'($urandom % 32) - 16;
        int y = int'($urandom % 32) - 16;
        send(first, a, c, ($urandom % 4) != 0, ($urandom % 8) == 0, x, y, 6'($urandom));
        first = 0;
        if ($urandom % 5 == 0) idle(1);
      end
    end
    bp = 0;
    idle(3);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule